// File: doc/BRIEF.md
# Serial Command Port with Register Bank

This block is the synchronous slave serial port of a converter-style peripheral. A host selects the port with an active-low select, clocks an 8-bit command into the serial data input, and then clocks 24 data bits (or 72 for the setup group) into or out of the port, most significant bit first. The command picks the offset, gain, configuration or conversion-data register, or the offset/gain/configuration trio as a single group. The command also carries a run/power-save control bit. The register contents are driven out in parallel so that the converter core can use them. The core delivers each finished result on a parallel bus with a one-cycle valid strobe.

The serial pins are sampled in the system clock domain through a synchronizer, and the serial clock edges are found there. When the continuous mode bit of the configuration register is set, the port signals a waiting result by pulling the serial output low while it is idle. Eight serial clocks then clear that indication, and the 24-bit result follows on the serial output.

Top module: `sckp_port`

## Requirements
- R1: After reset the offset register is 0, gain is 1.0 (24'h400000, 22 fraction bits), configuration is 0, the conversion data register is 0, pwr_save is 0, and sdo_oe is 0 while cs_n is high.
- R2: The command byte is decoded as follows. Bit 7 selects read (1) or write (0). Bits 6:4 select the target: 000 offset, 001 gain, 010 configuration, 011 conversion data, 100 the setup group. Bit 0 is the power-save bit. Bits 3:1 are ignored.
- R3: A single-register write takes 24 bits, MSB first, sampled on SCLK rising edges. The register changes only after the 24th bit has been taken.
- R4: A single-register read shifts 24 bits out MSB first. SDO changes on SCLK falling edges, and the first data bit appears after the falling edge that follows the command's 8th rising edge.
- R5: A setup-group access moves 72 bits in the order offset, gain, configuration, in both directions.
- R6: Select codes 101, 110 and 111 change no register and do not change pwr_save. They have no data phase, so the next byte is taken as a new command.
- R7: The conversion data register is read-only. A write command addressed to it consumes 24 bits and has no effect. The register loads res_data whenever res_valid is high.
- R8: Every non-reserved command copies its bit 0 into pwr_save (0 run, 1 power-save).
- R9: With cs_n held low the whole time, commands follow one another back to back without any re-framing.
- R10: cs_n high resets the port to command-wait and discards any partial transfer. Register contents are kept, and sdo_oe is low.
- R11: Configuration bit 1 is a read-only data flag. It is set by res_valid and cleared when a read of the conversion data register completes. Reading the configuration register alone, singly or in the group, does not clear it.
- R12: When configuration bit 0 (continuous) is 1 and the port is idle with the data flag set, SDO goes low. The next 8 SCLK cycles clear the indication. The 24-bit result then follows MSB first, and the data flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low port select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the port |
| sdo | output | 1 | Serial data out of the port |
| sdo_oe | output | 1 | Output enable for the SDO pad, high while selected |
| res_data | input | REG_W | Conversion result from the core |
| res_valid | input | 1 | One-cycle strobe that loads res_data |
| offset_q | output | REG_W | Offset register contents |
| gain_q | output | REG_W | Gain register contents |
| cfg_q | output | REG_W | Configuration contents, with the data flag in bit 1 |
| pwr_save | output | 1 | Run (0) or power-save (1) control |

## Verification
Each serial input passes through two synchronizer flops and an edge-detect register before it acts, so an SCLK edge takes effect about three system clocks after the bench drives it. The bench holds each SCLK phase for six system clocks and samples SDO at the end of the low phase. This is at least three cycles after the falling edge that moved SDO and before the next rising edge. Register outputs, pwr_save and the data flag are checked six cycles after cs_n is raised, when every commit has settled. The continuous-mode low indication is checked four cycles after the result strobe, which allows one cycle for the flag to set and one for the port to enter the indication state.

// File: rtl/sckp_pkg.sv
package sckp_pkg;

   typedef enum logic [2:0] {
      SEL_OFS  = 3'b000,
      SEL_GAIN = 3'b001,
      SEL_CFG  = 3'b010,
      SEL_DATA = 3'b011,
      SEL_GRP  = 3'b100,
      SEL_RV5  = 3'b101,
      SEL_RV6  = 3'b110,
      SEL_RV7  = 3'b111
   } sel_e;

   typedef enum logic [1:0] {
      ST_CMD,
      ST_XFER,
      ST_FLAG
   } st_e;

   localparam int CMD_W    = 8;
   localparam int CMD_RD   = 7;
   localparam int SEL_MSB  = 6;
   localparam int SEL_LSB  = 4;
   localparam int CMD_PS   = 0;
   localparam int CFG_CONT = 0;
   localparam int CFG_FLAG = 1;

   function automatic logic sel_reserved(input sel_e s);
      return (s == SEL_RV5) || (s == SEL_RV6) || (s == SEL_RV7);
   endfunction

endpackage

// File: rtl/sckp_sync.sv
module sckp_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("sckp_sync: STAGES must lie in 0..4");
      end
      if (STAGES == 0) begin : g_pass
         assign d_out = d_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d_in;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign d_out = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sckp_regs.sv
module sckp_regs
   import sckp_pkg::*;
#(
   parameter int REG_W     = 24,
   parameter int GAIN_FRAC = 22
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  sel_e                 wr_sel,
   input  logic [3*REG_W-1:0]   wr_data,
   input  logic                 rd_data_done,
   input  logic                 ps_we,
   input  logic                 ps_val,
   input  logic [REG_W-1:0]     res_data,
   input  logic                 res_valid,
   input  sel_e                 ld_sel,
   output logic [3*REG_W-1:0]   ld_word,
   output logic                 flag_req,
   output logic [REG_W-1:0]     offset_q,
   output logic [REG_W-1:0]     gain_q,
   output logic [REG_W-1:0]     cfg_q,
   output logic                 pwr_save
);

   localparam int GRP_W = 3 * REG_W;
   localparam logic [REG_W-1:0] GAIN_ONE = REG_W'(1) << GAIN_FRAC;
   localparam logic [REG_W-1:0] CFG_WMASK = ~(REG_W'(1) << CFG_FLAG);
   localparam logic [2*REG_W-1:0] PAD = '0;

   logic [REG_W-1:0] ofs_r, gain_r, cfg_r, data_r, cfg_view;
   logic             data_flag, ps_r;

   assign cfg_view = cfg_r | (REG_W'(data_flag) << CFG_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_r  <= '0;
         gain_r <= GAIN_ONE;
         cfg_r  <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_OFS:  ofs_r  <= wr_data[REG_W-1:0];
            SEL_GAIN: gain_r <= wr_data[REG_W-1:0];
            SEL_CFG:  cfg_r  <= wr_data[REG_W-1:0] & CFG_WMASK;
            SEL_GRP: begin
               ofs_r  <= wr_data[GRP_W-1 -: REG_W];
               gain_r <= wr_data[2*REG_W-1 -: REG_W];
               cfg_r  <= wr_data[REG_W-1:0] & CFG_WMASK;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_r    <= '0;
         data_flag <= 1'b0;
      end else begin
         if (res_valid) data_r <= res_data;
         if (res_valid)         data_flag <= 1'b1;
         else if (rd_data_done) data_flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ps_r <= 1'b0;
      else if (ps_we) ps_r <= ps_val;
   end

   always_comb begin
      case (ld_sel)
         SEL_OFS:  ld_word = {ofs_r, PAD};
         SEL_GAIN: ld_word = {gain_r, PAD};
         SEL_CFG:  ld_word = {cfg_view, PAD};
         SEL_DATA: ld_word = {data_r, PAD};
         SEL_GRP:  ld_word = {ofs_r, gain_r, cfg_view};
         default:  ld_word = '0;
      endcase
   end

   assign flag_req = cfg_r[CFG_CONT] & data_flag;
   assign offset_q = ofs_r;
   assign gain_q   = gain_r;
   assign cfg_q    = cfg_view;
   assign pwr_save = ps_r;

   // R6
   wr_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !sel_reserved(wr_sel));

   // R7
   wr_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_sel != SEL_DATA));

   // R3
   ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ofs_r));

   // R11
   flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_flag && !rd_data_done) |=> data_flag);

endmodule

// File: rtl/sckp_shifter.sv
module sckp_shifter
   import sckp_pkg::*;
#(
   parameter int REG_W     = 24,
   parameter int FLAG_CLKS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sclk_s,
   input  logic                 cs_n_s,
   input  logic                 sdi_s,
   input  logic                 flag_req,
   input  logic [3*REG_W-1:0]   ld_word,
   output sel_e                 ld_sel,
   output logic                 wr_en,
   output sel_e                 wr_sel,
   output logic [3*REG_W-1:0]   wr_data,
   output logic                 rd_data_done,
   output logic                 ps_we,
   output logic                 ps_val,
   output logic                 sdo,
   output logic                 sdo_oe
);

   localparam int GRP_W   = 3 * REG_W;
   localparam int CNT_MAX = (GRP_W > FLAG_CLKS) ? GRP_W : FLAG_CLKS;
   localparam int CNT_W   = $clog2(CNT_MAX);
   localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] FLAG_LAST = CNT_W'(FLAG_CLKS - 1);
   localparam logic [CNT_W-1:0] ONE_LAST  = CNT_W'(REG_W - 1);
   localparam logic [CNT_W-1:0] GRP_LAST  = CNT_W'(GRP_W - 1);

   st_e              state;
   logic [CNT_W-1:0] cnt, last_idx;
   logic [CMD_W-2:0] cmd_sr;
   logic [CMD_W-1:0] cmd_byte;
   logic [GRP_W-1:0] tx;
   logic [GRP_W-2:0] rx;
   logic             sclk_d, rise, fall, last, xf_rd, xf_grp, sdo_r;
   sel_e             xf_sel, cmd_sel;

   assign rise     = sclk_s & ~sclk_d & ~cs_n_s;
   assign fall     = ~sclk_s & sclk_d & ~cs_n_s;
   assign cmd_byte = {cmd_sr, sdi_s};
   assign cmd_sel  = sel_e'(cmd_byte[SEL_MSB:SEL_LSB]);
   assign last_idx = xf_grp ? GRP_LAST : ONE_LAST;
   assign last     = (cnt == last_idx);
   assign ld_sel   = (state == ST_FLAG) ? SEL_DATA : cmd_sel;

   assign wr_en        = rise && (state == ST_XFER) && last && !xf_rd && (xf_sel != SEL_DATA);
   assign wr_sel       = xf_sel;
   assign wr_data      = {rx, sdi_s};
   assign rd_data_done = rise && (state == ST_XFER) && last && xf_rd && (xf_sel == SEL_DATA);
   assign ps_we        = rise && (state == ST_CMD) && (cnt == CMD_LAST) && !sel_reserved(cmd_sel);
   assign ps_val       = cmd_byte[CMD_PS];
   assign sdo          = sdo_r;
   assign sdo_oe       = ~cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         state  <= ST_CMD;
         cnt    <= '0;
         cmd_sr <= '0;
         tx     <= '0;
         rx     <= '0;
         xf_rd  <= 1'b0;
         xf_grp <= 1'b0;
         xf_sel <= SEL_OFS;
         sdo_r  <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         if (cs_n_s) begin
            state <= ST_CMD;
            cnt   <= '0;
            sdo_r <= 1'b1;
         end else begin
            case (state)
               ST_CMD: begin
                  if (rise) begin
                     cmd_sr <= cmd_byte[CMD_W-2:0];
                     if (cnt == CMD_LAST) begin
                        cnt <= '0;
                        if (!sel_reserved(cmd_sel)) begin
                           state  <= ST_XFER;
                           xf_rd  <= cmd_byte[CMD_RD];
                           xf_sel <= cmd_sel;
                           xf_grp <= (cmd_sel == SEL_GRP);
                           tx     <= ld_word;
                        end
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end else if (fall) begin
                     sdo_r <= 1'b1;
                  end else if ((cnt == '0) && flag_req) begin
                     state <= ST_FLAG;
                     sdo_r <= 1'b0;
                  end
               end
               ST_FLAG: begin
                  if (rise) begin
                     if (cnt == FLAG_LAST) begin
                        cnt    <= '0;
                        state  <= ST_XFER;
                        xf_rd  <= 1'b1;
                        xf_sel <= SEL_DATA;
                        xf_grp <= 1'b0;
                        tx     <= ld_word;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end else if (fall) begin
                     sdo_r <= 1'b0;
                  end
               end
               ST_XFER: begin
                  if (rise) begin
                     rx <= {rx[GRP_W-3:0], sdi_s};
                     if (last) begin
                        state <= ST_CMD;
                        cnt   <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end else if (fall && xf_rd) begin
                     sdo_r <= tx[GRP_W-1];
                     tx    <= tx << 1;
                  end
               end
               default: state <= ST_CMD;
            endcase
         end
      end
   end

   // R10
   cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> ((cnt == '0) && (state == ST_CMD) && sdo_r));

   // R12
   flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FLAG) |-> !sdo);

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_XFER) |-> (cnt <= GRP_LAST));

endmodule

// File: rtl/sckp_port.sv
module sckp_port
   import sckp_pkg::*;
#(
   parameter int REG_W       = 24,
   parameter int GAIN_FRAC   = 22,
   parameter int SYNC_STAGES = 2,
   parameter int FLAG_CLKS   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sclk,
   input  logic             sdi,
   output logic             sdo,
   output logic             sdo_oe,
   input  logic [REG_W-1:0] res_data,
   input  logic             res_valid,
   output logic [REG_W-1:0] offset_q,
   output logic [REG_W-1:0] gain_q,
   output logic [REG_W-1:0] cfg_q,
   output logic             pwr_save
);

   localparam int GRP_W = 3 * REG_W;

   generate
      if (REG_W < 8) begin : g_bad_w
         $error("sckp_port: REG_W must be at least 8");
      end
      if (GAIN_FRAC >= REG_W) begin : g_bad_g
         $error("sckp_port: GAIN_FRAC must be below REG_W");
      end
      if (FLAG_CLKS < 1) begin : g_bad_f
         $error("sckp_port: FLAG_CLKS must be positive");
      end
   endgenerate

   logic [2:0]       pin_s;
   logic             flag_req, wr_en, rd_data_done, ps_we, ps_val;
   logic [GRP_W-1:0] ld_word, wr_data;
   sel_e             ld_sel, wr_sel;

   sckp_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({cs_n, sclk, sdi}),
      .d_out (pin_s)
   );

   sckp_shifter #(
      .REG_W     (REG_W),
      .FLAG_CLKS (FLAG_CLKS)
   ) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .sclk_s       (pin_s[1]),
      .cs_n_s       (pin_s[2]),
      .sdi_s        (pin_s[0]),
      .flag_req     (flag_req),
      .ld_word      (ld_word),
      .ld_sel       (ld_sel),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .rd_data_done (rd_data_done),
      .ps_we        (ps_we),
      .ps_val       (ps_val),
      .sdo          (sdo),
      .sdo_oe       (sdo_oe)
   );

   sckp_regs #(
      .REG_W     (REG_W),
      .GAIN_FRAC (GAIN_FRAC)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .rd_data_done (rd_data_done),
      .ps_we        (ps_we),
      .ps_val       (ps_val),
      .res_data     (res_data),
      .res_valid    (res_valid),
      .ld_sel       (ld_sel),
      .ld_word      (ld_word),
      .flag_req     (flag_req),
      .offset_q     (offset_q),
      .gain_q       (gain_q),
      .cfg_q        (cfg_q),
      .pwr_save     (pwr_save)
   );

endmodule

// File: tb/tb_sckp_port.sv
module tb_sckp_port;

   localparam int HALF = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdi = 1'b0;
   logic        sdo, sdo_oe, pwr_save;
   logic [23:0] res_data = '0;
   logic        res_valid = 1'b0;
   logic [23:0] offset_q, gain_q, cfg_q;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sckp_port dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .res_data(res_data), .res_valid(res_valid),
      .offset_q(offset_q), .gain_q(gain_q), .cfg_q(cfg_q), .pwr_save(pwr_save)
   );

   task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_io(input logic b, output logic o);
      sdi = b;
      wait_clk(HALF);
      o = sdo;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
   endtask

   function automatic logic [7:0] mk(input logic rd, input logic [2:0] sel, input logic ps);
      return {rd, sel, 3'b000, ps};
   endfunction

   task automatic xact(input logic [7:0] cmd, input logic [71:0] wdat, input int nbits,
                       output logic [71:0] rdat);
      logic o;
      for (int i = 0; i < 8; i++) bit_io(cmd[7-i], o);
      rdat = '0;
      for (int i = 0; i < nbits; i++) begin
         bit_io(wdat[nbits-1-i], o);
         rdat = {rdat[70:0], o};
      end
   endtask

   task automatic cs_lo();
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic cs_hi();
      cs_n = 1'b1;
      wait_clk(HALF);
   endtask

   task automatic wr_reg(input logic [2:0] sel, input logic [23:0] v);
      logic [71:0] r;
      cs_lo();
      xact(mk(1'b0, sel, 1'b0), {48'd0, v}, 24, r);
      cs_hi();
   endtask

   task automatic rd_reg(input logic [2:0] sel, output logic [23:0] v);
      logic [71:0] r;
      cs_lo();
      xact(mk(1'b1, sel, 1'b0), '0, 24, r);
      cs_hi();
      v = r[23:0];
   endtask

   task automatic pulse_res(input logic [23:0] v);
      res_data  = v;
      res_valid = 1'b1;
      wait_clk(1);
      res_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [23:0] v;
      chk("R1 offset", offset_q, 0);
      chk("R1 gain", gain_q, 24'h400000);
      chk("R1 cfg", cfg_q, 0);
      chk("R1 pwr_save", pwr_save, 0);
      chk("R1 sdo_oe", sdo_oe, 0);
      rd_reg(3'b011, v);
      chk("R1 data reg", v, 0);
   endtask

   task automatic t_single();
      logic [23:0] v;
      wr_reg(3'b000, 24'hA5C301);
      chk("R3 offset write", offset_q, 24'hA5C301);
      wr_reg(3'b001, 24'h3FF00F);
      chk("R3 gain write", gain_q, 24'h3FF00F);
      wr_reg(3'b010, 24'h81F0F4);
      chk("R3 R11 cfg write flag bit ignored", cfg_q, 24'h81F0F4);
      rd_reg(3'b000, v);
      chk("R4 offset read", v, 24'hA5C301);
      rd_reg(3'b001, v);
      chk("R4 R2 gain read", v, 24'h3FF00F);
      rd_reg(3'b010, v);
      chk("R4 cfg read", v, 24'h81F0F4);
   endtask

   task automatic t_group();
      logic [71:0] r;
      cs_lo();
      xact(mk(1'b0, 3'b100, 1'b0), {24'h111111, 24'h222222, 24'h333330}, 72, r);
      cs_hi();
      chk("R5 group write offset", offset_q, 24'h111111);
      chk("R5 group write gain", gain_q, 24'h222222);
      chk("R5 group write cfg", cfg_q, 24'h333330);
      cs_lo();
      xact(mk(1'b1, 3'b100, 1'b0), '0, 72, r);
      cs_hi();
      chk("R5 group read order", r, {24'h111111, 24'h222222, 24'h333330});
   endtask

   task automatic t_reserved();
      logic [71:0] r;
      logic [23:0] v;
      cs_lo();
      xact(mk(1'b1, 3'b000, 1'b1), '0, 24, r);
      cs_hi();
      chk("R8 pwr_save set", pwr_save, 1);
      for (int s = 5; s < 8; s++) begin
         cs_lo();
         xact(mk(1'b0, 3'(s), 1'b0), '0, 0, r);
         xact(mk(1'b0, 3'b000, 1'b1), 72'h0000_0000_0000_C0FFEE, 24, r);
         cs_hi();
         chk("R6 reserved no data phase", offset_q, 24'hC0FFEE);
         chk("R6 reserved keeps pwr_save", pwr_save, 1);
         wr_reg(3'b000, 24'h111111);
      end
      chk("R6 gain kept", gain_q, 24'h222222);
      chk("R8 pwr_save cleared", pwr_save, 0);
      rd_reg(3'b001, v);
      chk("R6 gain readback", v, 24'h222222);
   endtask

   task automatic t_readonly();
      logic [23:0] v;
      pulse_res(24'h123456);
      rd_reg(3'b011, v);
      chk("R7 data loads result", v, 24'h123456);
      wr_reg(3'b011, 24'hFEDCBA);
      rd_reg(3'b011, v);
      chk("R7 data write ignored", v, 24'h123456);
      chk("R7 others kept", {offset_q, gain_q}, {24'h111111, 24'h222222});
   endtask

   task automatic t_three_wire();
      logic [71:0] r;
      cs_lo();
      xact(mk(1'b0, 3'b001, 1'b0), 72'h0000_0000_0000_5A5A5A, 24, r);
      xact(mk(1'b1, 3'b001, 1'b0), '0, 24, r);
      xact(mk(1'b0, 3'b000, 1'b0), 72'h0000_0000_0000_0F0F0F, 24, r);
      xact(mk(1'b1, 3'b000, 1'b0), '0, 24, r);
      chk("R9 back-to-back read", r[23:0], 24'h0F0F0F);
      cs_hi();
      chk("R9 gain via held select", gain_q, 24'h5A5A5A);
   endtask

   task automatic t_port_reset();
      logic o;
      logic [71:0] r;
      cs_lo();
      for (int i = 0; i < 8; i++) bit_io(mk(1'b0, 3'b000, 1'b0)[7-i], o);
      for (int i = 0; i < 10; i++) bit_io(1'b1, o);
      cs_hi();
      chk("R10 partial discarded", offset_q, 24'h0F0F0F);
      chk("R10 sdo_oe low", sdo_oe, 0);
      cs_lo();
      xact(mk(1'b1, 3'b001, 1'b0), '0, 24, r);
      cs_hi();
      chk("R10 command-wait after reset", r[23:0], 24'h5A5A5A);
   endtask

   task automatic t_flag();
      logic [23:0] v;
      wr_reg(3'b010, 24'h000000);
      pulse_res(24'h00ABCD);
      wait_clk(2);
      chk("R11 flag set", cfg_q[1], 1);
      rd_reg(3'b010, v);
      chk("R11 cfg read shows flag", v[1], 1);
      rd_reg(3'b010, v);
      chk("R11 cfg read keeps flag", v[1], 1);
      rd_reg(3'b011, v);
      chk("R11 data read value", v, 24'h00ABCD);
      chk("R11 data read clears flag", cfg_q[1], 0);
   endtask

   task automatic t_continuous();
      logic o;
      logic [23:0] got;
      wr_reg(3'b010, 24'h000001);
      chk("R12 idle sdo high", sdo, 1);
      cs_lo();
      pulse_res(24'hC3A501);
      wait_clk(4);
      chk("R12 sdo low on ready", sdo, 0);
      for (int i = 0; i < 8; i++) begin
         bit_io(1'b0, o);
         if (i == 7) chk("R12 sdo low during clear", o, 0);
      end
      got = '0;
      for (int i = 0; i < 24; i++) begin
         bit_io(1'b0, o);
         got = {got[22:0], o};
      end
      chk("R12 result after clear", got, 24'hC3A501);
      wait_clk(HALF);
      chk("R12 sdo idle after result", sdo, 1);
      cs_hi();
      chk("R12 flag cleared", cfg_q[1], 0);
      wr_reg(3'b010, 24'h000000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(4);
      t_reset();
      t_single();
      t_group();
      t_reserved();
      t_readonly();
      t_three_wire();
      t_port_reset();
      t_flag();
      t_continuous();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule